// File: doc/BRIEF.md
# Stackless Dictionary Chain Decoder

This block turns a stream of dictionary indices back into the byte stream they stand for. The dictionary is produced offline by a global, LZW-style compressor that never adds entries at decode time. Every entry pairs a back-pointer to a shorter string with the last byte of its own string. The 256 single-byte strings are built in and need no storage. Software first fills the remaining entries through a sequential load port and then pulses `start`. From then on the decoder takes one index at a time. For each index it follows the back-pointer chain down to a single-byte root and emits one byte per cycle.

The offline compressor runs over the data back to front, and the resulting indices are then presented last-first. Under that scheme, the order in which a chain is walked is already the forward order of the data. No last-in-first-out buffer is needed. Concatenating the emitted bytes reproduces the original data exactly.

Both data interfaces use valid/ready handshakes. An index moves when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` stays low until the decoder is armed and whenever a chain is still being emitted. A byte moves when `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented byte, its end-of-chain marker and `out_valid` hold unchanged. No byte is skipped or repeated. Load and start pins are plain controls, and `err` is a plain sticky status pin.

Top module: `dict_chain_decoder`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `err` are all 0.
- R2: `in_ready` stays 0 until a one-cycle `start` pulse has been seen. After the pulse, `in_ready` is 1 whenever no chain is in progress.
- R3: An accepted index below 256 produces exactly one byte. That byte equals the index's low 8 bits, and `out_last` is 1 with it.
- R4: An accepted index of 256 or more first emits its stored byte and then continues at its stored back-pointer. Each further step emits the byte of the entry it reaches. The walk stops after the root byte (index below 256), which is the only byte of the chain with `out_last` = 1.
- R5: While a chain is in progress, `out_valid` is 1 every cycle. With `out_ready` held at 1, one byte leaves per cycle, starting the cycle after the index is accepted.
- R6: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_sym` and `out_last` stay unchanged in the next cycle.
- R7: `in_ready` is 0 in every cycle in which `out_valid` is 1, so a new index is taken only after the previous chain's last byte has left.
- R8: An accepted index greater than or equal to 256 plus the number of loaded entries sets `err` to 1. That index produces no output. `err` stays 1 until reset, and later valid indices still decode normally.
- R9: The k-th load (k counting from 0) while idle stores a back-pointer `ld_prefix` and a byte `ld_sym` as the entry for index 256 + k. Loads beyond the storage capacity are ignored.
- R10: Loads presented after the `start` pulse are ignored and do not enlarge the dictionary.
- R11: Feeding the indices of a compressed stream last-first yields a byte stream identical to the original data, for any pattern of `in_valid` gaps and `out_ready` stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms decoding and closes loading |
| ld_valid | input | 1 | Write the next dictionary entry |
| ld_prefix | input | IDX_W | Back-pointer of the entry being loaded (must be lower than its own index) |
| ld_sym | input | 8 | Final byte of the entry being loaded |
| in_valid | input | 1 | Index input valid |
| in_ready | output | 1 | Index input ready |
| in_idx | input | IDX_W | Dictionary index |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted by the consumer |
| out_sym | output | 8 | Decoded byte |
| out_last | output | 1 | Marks the final byte of the current chain |
| err | output | 1 | Sticky flag: an out-of-range index was received |

## Verification
The hardest condition to reach from the ports is back-pressure in the middle of a long chain. The stall must land while the walk is part-way down the back-pointers, with the next index already waiting. It must also be followed by a release that lands exactly on the root byte.

The stimulus reaches this with a generated dictionary in which most new entries point at the previous entry, which produces deep chains. Random `out_ready` then stalls these walks at arbitrary depths, and a directed step holds `out_ready` low for several cycles mid-chain. The other hard condition is proving that a load after `start` has no effect. Since the dictionary size is not visible at the ports, this is shown by the range error that fires on the index the ignored load would have created.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int SYM_W = 8;
  localparam int ROOTS = 1 << SYM_W;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/dcd_dict_store.sv
module dcd_dict_store
  import dcd_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_prefix,
  input  sym_t             ld_sym,
  input  logic [IDX_W-1:0] rd_idx,
  output sym_t             rd_sym,
  output logic [IDX_W-1:0] rd_prefix,
  output logic             rd_root,
  output logic [IDX_W:0]   dict_size
);
  localparam int ENTRIES = DEPTH - ROOTS;
  localparam int ENT_W   = $clog2(ENTRIES);
  localparam int CNT_W   = $clog2(ENTRIES + 1);
  localparam int WORD_W  = IDX_W + SYM_W;

  logic [WORD_W-1:0] mem [ENTRIES];
  logic [CNT_W-1:0]  count;
  logic              wr_en;
  logic [IDX_W-1:0]  offset;
  logic [WORD_W-1:0] word;

  assign wr_en = ld_valid && !armed && (count < CNT_W'(ENTRIES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (wr_en) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[ENT_W-1:0]] <= {ld_prefix, ld_sym};
  end

  assign dict_size = (IDX_W+1)'(ROOTS) + (IDX_W+1)'(count);
  assign rd_root   = rd_idx < IDX_W'(ROOTS);
  assign offset    = rd_idx - IDX_W'(ROOTS);

  always_comb begin
    word = '0;
    if (!rd_root && offset < IDX_W'(ENTRIES)) word = mem[offset[ENT_W-1:0]];
  end

  assign rd_sym    = rd_root ? rd_idx[SYM_W-1:0] : word[SYM_W-1:0];
  assign rd_prefix = word[WORD_W-1:SYM_W];

  // R10: once armed, the loaded entry count never moves
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(count));
endmodule

// File: rtl/dcd_walker.sv
module dcd_walker
  import dcd_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [IDX_W:0]   dict_size,
  output logic             out_valid,
  input  logic             out_ready,
  output sym_t             out_sym,
  output logic             out_last,
  output logic             err,
  output logic             armed,
  output logic [IDX_W-1:0] rd_idx,
  input  sym_t             rd_sym,
  input  logic [IDX_W-1:0] rd_prefix,
  input  logic             rd_root
);
  logic             busy;
  logic [IDX_W-1:0] cur;
  logic             in_fire;
  logic             in_range;

  assign in_ready = armed && !busy;
  assign in_fire  = in_valid && in_ready;
  assign in_range = (IDX_W+1)'(in_idx) < dict_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      cur   <= '0;
      err   <= 1'b0;
    end else begin
      if (start) armed <= 1'b1;
      if (in_fire) begin
        if (in_range) begin
          busy <= 1'b1;
          cur  <= in_idx;
        end else begin
          err <= 1'b1;
        end
      end else if (busy && out_ready) begin
        if (rd_root) busy <= 1'b0;
        else         cur  <= rd_prefix;
      end
    end
  end

  assign rd_idx    = cur;
  assign out_valid = busy;
  assign out_sym   = rd_sym;
  assign out_last  = rd_root;

  // R6: a stalled byte holds still
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_last));
  // R7: no index taken while a chain is being emitted
  a_r7_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R8: error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R8: an out-of-range index raises the flag and yields nothing
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ((IDX_W+1)'(in_idx) >= dict_size) |=> err && !out_valid);
  // R4: a non-final byte is followed by another byte of the same chain
  a_r4_continue: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);
endmodule

// File: rtl/dict_chain_decoder.sv
module dict_chain_decoder
  import dcd_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_prefix,
  input  logic [7:0]       ld_sym,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_sym,
  output logic             out_last,
  output logic             err
);
  logic             armed;
  logic [IDX_W-1:0] rd_idx;
  sym_t             rd_sym;
  logic [IDX_W-1:0] rd_prefix;
  logic             rd_root;
  logic [IDX_W:0]   dict_size;

  dcd_dict_store #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .armed(armed),
    .ld_valid(ld_valid), .ld_prefix(ld_prefix), .ld_sym(ld_sym),
    .rd_idx(rd_idx), .rd_sym(rd_sym), .rd_prefix(rd_prefix),
    .rd_root(rd_root), .dict_size(dict_size)
  );

  dcd_walker #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .dict_size(dict_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
    .out_last(out_last), .err(err), .armed(armed),
    .rd_idx(rd_idx), .rd_sym(rd_sym), .rd_prefix(rd_prefix), .rd_root(rd_root)
  );
endmodule

// File: tb/tb_dict_chain_decoder.sv
module tb_dict_chain_decoder;
  localparam int IDX_W = 12;
  localparam int NLOAD = 48;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, ld_valid = 0, in_valid = 0, out_ready = 0;
  logic [IDX_W-1:0] ld_prefix = '0, in_idx = '0;
  logic [7:0] ld_sym = '0;
  logic in_ready, out_valid, out_last, err;
  logic [7:0] out_sym;

  always #5 clk = ~clk;

  dict_chain_decoder #(.IDX_W(IDX_W), .DEPTH(1024)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
    .ld_prefix(ld_prefix), .ld_sym(ld_sym), .in_valid(in_valid),
    .in_ready(in_ready), .in_idx(in_idx), .out_valid(out_valid),
    .out_ready(out_ready), .out_sym(out_sym), .out_last(out_last), .err(err)
  );

  int checks = 0, errors = 0, cycles = 0;
  int bpre [NLOAD];
  int bsym [NLOAD];
  int feed_q[$];
  logic [8:0] exp_q[$];
  int ready_mode = 2;   // 0 always, 1 never, 2 random
  string tag = "R11";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected chain of an index: {last, byte} in emission order
  task automatic push_chain(input int idx);
    int i = idx;
    while (1) begin
      if (i < 256) begin
        exp_q.push_back({1'b1, 8'(i)});
        break;
      end
      exp_q.push_back({1'b0, 8'(bsym[i-256])});
      i = bpre[i-256];
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (feed_q.size() > 0 && (ready_mode != 2 || $urandom % 4 != 0)) begin
      in_valid = 1; in_idx = IDX_W'(feed_q[0]);
    end else in_valid = 0;
    out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'b0 : ($urandom % 3 != 0);
    #1;
    if (out_valid) chk(in_ready == 0, "R7", in_ready, 0);
    if (exp_q.size() > 0) chk(out_valid == 1, "R5", out_valid, 1);
    if (out_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected byte", out_sym, -1);
      else begin
        chk({out_last, out_sym} == exp_q[0],
            out_ready ? tag : "R6", {out_last, out_sym}, exp_q[0]);
        if (out_ready) void'(exp_q.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      int idx = feed_q.pop_front();
      if (idx < 256 + NLOAD) push_chain(idx);
    end
    cycles++;
  endtask

  task automatic drain();
    int lim = 0;
    while ((feed_q.size() > 0 || exp_q.size() > 0) && lim < 20000) begin
      step(); lim++;
    end
    if (lim >= 20000) chk(0, "watchdog drain", lim, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20011));
    for (int k = 0; k < NLOAD; k++) begin
      bsym[k] = $urandom % 256;
      if (k > 0 && $urandom % 10 < 7) bpre[k] = 256 + k - 1;
      else bpre[k] = $urandom % (256 + k);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 0, "R1 in_ready", in_ready, 0);
    chk(err == 0, "R1 err", err, 0);
    @(negedge clk) rst_n = 1;

    // R9: sequential load while idle
    for (int k = 0; k < NLOAD; k++) begin
      @(negedge clk);
      ld_valid = 1; ld_prefix = IDX_W'(bpre[k]); ld_sym = 8'(bsym[k]);
      #1 chk(in_ready == 0, "R2 not armed", in_ready, 0);
    end
    @(negedge clk) ld_valid = 0;
    start = 1;
    @(negedge clk) start = 0;
    #1 chk(in_ready == 1, "R2 armed", in_ready, 1);

    // R3: root indices
    tag = "R3";
    feed_q.push_back(8'h41); feed_q.push_back(0); feed_q.push_back(255);
    ready_mode = 0; drain();

    // R4/R5: longest chain at full rate
    tag = "R4";
    feed_q.push_back(256 + NLOAD - 1); feed_q.push_back(256);
    drain();

    // R6: stall mid-chain
    tag = "R6";
    feed_q.push_back(256 + NLOAD - 2);
    step(); step(); step();
    ready_mode = 1; repeat (4) step();
    ready_mode = 0; drain();

    // R9/R11: random stream with gaps and stalls
    tag = "R11";
    ready_mode = 2;
    for (int n = 0; n < 300; n++) feed_q.push_back($urandom % (256 + NLOAD));
    drain();
    @(negedge clk) #1 chk(err == 0, "R8 no false error", err, 0);

    // R10: load while armed is ignored; the would-be index is out of range
    @(negedge clk); ld_valid = 1; ld_prefix = 12'd5; ld_sym = 8'h99;
    @(negedge clk) ld_valid = 0;
    tag = "R10";
    feed_q.push_back(256 + NLOAD);
    ready_mode = 0;
    repeat (4) step();
    chk(err == 1, "R10 load ignored (err)", err, 1);
    chk(out_valid == 0, "R8 dropped", out_valid, 0);

    // R8: sticky, later valid indices still decode
    tag = "R8";
    feed_q.push_back(1000); feed_q.push_back(256 + 3); feed_q.push_back(7);
    drain();
    step();
    chk(err == 1, "R8 sticky", err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule